// File: doc/BRIEF.md
# Asynchronous Memory Strobe Controller

This block runs single read and write cycles on an external asynchronous device such as an SRAM, a flash part or a memory-mapped peripheral. The host places an address, byte enables, write data and a direction flag on a request/acknowledge port. The block then moves through three timed phases. The setup phase drives the select lines with the strobes inactive. The strobe phase pulls the read or write strobe low. The hold phase keeps the select lines stable with the strobes released. All timing is counted in periods of the interface clock. Reads and writes each have their own programmable setup, strobe and hold lengths.

A ready input from the device can lengthen the strobe phase. The block passes ready through a two-flop synchronizer, so the device may drive it asynchronously. The block only looks at ready during the last two programmed strobe cycles. While ready is low in that window, the strobe is held one cycle at a time. Once ready is seen high again, the strobe finishes two cycles later. On a read, data is taken from the memory bus in the final strobe cycle. It is returned to the host with the acknowledge pulse, which comes in the last hold cycle.

Top module: `asmem_strobe_ctrl`

## Requirements
- R1: While reset is high and after it is released, with no request: chip enable, read strobe, write strobe and output enable are all high (inactive), byte enables are all ones, write data enable is 0 and ack is 0.
- R2: A request taken in idle starts the setup phase in the next cycle. Setup lasts the read-setup or write-setup field cycles, picked by the direction flag (1 = write). Chip enable is low, address and active-low byte enables (bit i low for requested byte i) are stable, and both strobes are high.
- R3: The strobe phase follows setup. For the request's direction it lasts the read-strobe or write-strobe field cycles, and only that direction's strobe goes low.
- R4: The hold phase follows strobe and lasts the read-hold or write-hold field cycles. The selects keep their values throughout. Ack is high for exactly one cycle, the last hold cycle, and chip enable returns high in the next cycle.
- R5: A phase-length field of zero gives a phase of one cycle.
- R6: On a read, output enable is low in exactly the read strobe cycles. On a write, output enable stays high. The read strobe and the write strobe are never low together.
- R7: On a write, the write data enable is 1 and the write data output holds the request data in every cycle from setup through hold. The enable is 0 in all other cycles.
- R8: On a read, the read data output holds the memory bus value from the last strobe cycle. It is valid in the ack cycle and stays unchanged afterwards until the next read.
- R9: Ready is synchronized through two clock edges. Ready being low is ignored unless the synchronized value is low during one of the final two programmed strobe cycles. A low that ends before then leaves the strobe at its programmed length.
- R10: While the synchronized ready is low in that window, the strobe keeps extending. It ends two cycles after the synchronized ready is seen high. If ready is low from the start of the access and rises during strobe cycle C (C = programmed length, counting from 1), the strobe lasts C+3 cycles.
- R11: If a new request is already present in the cycle after ack, exactly one idle cycle (chip enable high) separates the two accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host access request, sampled in idle |
| req_we | input | 1 | Direction flag, 1 = write |
| req_addr | input | ADDR_W | Word address |
| req_be | input | BE_W | Byte enables, active high |
| req_wdata | input | DATA_W | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Read data captured from the bus |
| rd_setup | input | LEN_W | Read setup length |
| rd_strobe | input | LEN_W | Read strobe length |
| rd_hold | input | LEN_W | Read hold length |
| wr_setup | input | LEN_W | Write setup length |
| wr_strobe | input | LEN_W | Write strobe length |
| wr_hold | input | LEN_W | Write hold length |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_be_n | output | BE_W | Byte enables, active low |
| mem_addr | output | ADDR_W | Address to memory |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_wdata | output | DATA_W | Write data to memory bus |
| mem_wdata_en | output | 1 | Drive enable for the write data bus |
| mem_rdata | input | DATA_W | Data from memory bus |
| mem_ready | input | 1 | Asynchronous ready from the device |

## Verification
A request driven before a rising edge shows up as chip enable low in the cycle after that edge. After that, every phase boundary and the ack pulse land on clock edges set by the programmed lengths. Read data is already registered in the ack cycle. A change on ready takes two edges to reach the sequencer, so an extended strobe is due exactly three cycles after the programmed count when ready rises in the last programmed strobe cycle. The bench samples every output at the falling edge and counts setup, strobe and hold cycles one by one. It compares each count with the length worked out from the requirements, and checks the bus values and the one idle cycle after ack at the matching falling edges.

// File: rtl/amc_pkg.sv
package amc_pkg;

    parameter int unsigned PH_LEN_W = 4;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef struct packed {
        logic [PH_LEN_W-1:0] setup;
        logic [PH_LEN_W-1:0] strobe;
        logic [PH_LEN_W-1:0] hold;
    } phase_times_t;

    // Counter reload value: a phase of N cycles counts N-1 down to 0,
    // and a zero field behaves as a one-cycle phase.
    function automatic logic [PH_LEN_W-1:0] last_idx(input logic [PH_LEN_W-1:0] f);
        return (f == '0) ? '0 : f - 1'b1;
    endfunction

endpackage

// File: rtl/amc_ready_sync.sv
module amc_ready_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rdy_async,
    output logic rdy_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= rdy_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign rdy_sync = chain[STAGES-1];
endmodule

// File: rtl/amc_phase_seq.sv
module amc_phase_seq
    import amc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  phase_times_t times,
    input  logic         rdy,
    output phase_e       phase,
    output logic         last_strobe,
    output logic         done
);
    logic [PH_LEN_W-1:0] cnt;
    phase_times_t        tm;
    logic                in_window;

    assign in_window = (phase == PH_STROBE) && (cnt <= 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            tm    <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_SETUP;
                        cnt   <= last_idx(times.setup);
                        tm    <= times;
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_STROBE;
                        cnt   <= last_idx(tm.strobe);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (in_window && !rdy) begin
                        cnt <= 1;   // park two cycles from the end
                    end else if (cnt == '0) begin
                        phase <= PH_HOLD;
                        cnt   <= last_idx(tm.hold);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) phase <= PH_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign last_strobe = (phase == PH_STROBE) && (cnt == '0) && rdy;
    assign done        = (phase == PH_HOLD) && (cnt == '0);

    // R10: a low ready inside the window keeps the strobe going
    assert_ready_stretch_R10: assert property (@(posedge clk) disable iff (rst)
        (in_window && !rdy) |=> (phase == PH_STROBE))
        else $error("strobe ended while ready low");

    // R4: completion returns to idle and is a single-cycle pulse
    assert_back_to_idle_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> (phase == PH_IDLE && !done))
        else $error("no idle after completion");

endmodule

// File: rtl/asmem_strobe_ctrl.sv
module asmem_strobe_ctrl
    import amc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned BE_W      = DATA_W / 8,
    parameter int unsigned LEN_W     = PH_LEN_W,
    parameter int unsigned RDY_SYNC  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    input  logic [LEN_W-1:0]  rd_setup,
    input  logic [LEN_W-1:0]  rd_strobe,
    input  logic [LEN_W-1:0]  rd_hold,
    input  logic [LEN_W-1:0]  wr_setup,
    input  logic [LEN_W-1:0]  wr_strobe,
    input  logic [LEN_W-1:0]  wr_hold,
    output logic              mem_ce_n,
    output logic [BE_W-1:0]   mem_be_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_oe_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_en,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    phase_e       phase;
    phase_times_t times;
    logic         rdy_s;
    logic         last_strobe;
    logic         accept;
    logic         we_q;
    logic [BE_W-1:0] be_q;
    logic         active;
    logic         strobing;

    assign times  = req_we ? '{setup: wr_setup, strobe: wr_strobe, hold: wr_hold}
                           : '{setup: rd_setup, strobe: rd_strobe, hold: rd_hold};
    assign accept = req && (phase == PH_IDLE);

    amc_ready_sync #(.STAGES(RDY_SYNC)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .rdy_async (mem_ready),
        .rdy_sync  (rdy_s)
    );

    amc_phase_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .times       (times),
        .rdy         (rdy_s),
        .phase       (phase),
        .last_strobe (last_strobe),
        .done        (ack)
    );

    // request capture: selects stay frozen for the whole access
    always_ff @(posedge clk) begin
        if (rst) begin
            we_q      <= 1'b0;
            be_q      <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (accept) begin
            we_q      <= req_we;
            be_q      <= req_be;
            mem_addr  <= req_addr;
            mem_wdata <= req_wdata;
        end
    end

    // read data taken from the bus in the final strobe cycle
    always_ff @(posedge clk) begin
        if (rst)                      rdata <= '0;
        else if (last_strobe && !we_q) rdata <= mem_rdata;
    end

    assign active       = (phase != PH_IDLE);
    assign strobing     = (phase == PH_STROBE);
    assign mem_ce_n     = !active;
    assign mem_be_n     = active ? ~be_q : '1;
    assign mem_rd_n     = !(strobing && !we_q);
    assign mem_wr_n     = !(strobing && we_q);
    assign mem_oe_n     = mem_rd_n;
    assign mem_wdata_en = active && we_q;

    // R2: address and byte enables do not move while chip enable stays low
    assert_select_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !$past(mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)))
        else $error("select changed mid-access");

    // R4: ack only inside an access
    assert_ack_in_access_R4: assert property (@(posedge clk) disable iff (rst)
        ack |-> !mem_ce_n)
        else $error("ack outside access");

    // R6: strobes mutually exclusive
    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_n || mem_wr_n))
        else $error("both strobes low");

    // R7: write bus driven only during a write access
    assert_wdata_window_R7: assert property (@(posedge clk) disable iff (rst)
        mem_wdata_en |-> (!mem_ce_n && mem_oe_n))
        else $error("write data driven outside write access");

endmodule

// File: tb/asmem_strobe_ctrl_test.sv
module asmem_strobe_ctrl_test;

    typedef struct packed {
        logic        we;
        logic [19:0] addr;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [31:0] rd;
        logic [3:0]  s;
        logic [3:0]  t;
        logic [3:0]  h;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 20'h12345, 4'hF, 32'h0,        32'hDEADBEEF, 4'd2, 4'd3, 4'd1},
        '{1'b1, 20'h0ABCD, 4'h3, 32'hCAFE1234, 32'h0,        4'd1, 4'd4, 4'd2},
        '{1'b0, 20'hFFFFF, 4'h1, 32'h0,        32'h5A5AA5A5, 4'd0, 4'd0, 4'd0},
        '{1'b1, 20'h00001, 4'h8, 32'h13579BDF, 32'h0,        4'd0, 4'd0, 4'd0},
        '{1'b0, 20'h55AA5, 4'h6, 32'h0,        32'h0F0F1E1E, 4'd5, 4'd2, 4'd4},
        '{1'b1, 20'h3C3C3, 4'hF, 32'hA5A5F00D, 32'h0,        4'd3, 4'd15, 4'd3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        ack;
    logic [31:0] rdata;
    logic [3:0]  rd_setup = 4'd1, rd_strobe = 4'd1, rd_hold = 4'd1;
    logic [3:0]  wr_setup = 4'd1, wr_strobe = 4'd1, wr_hold = 4'd1;
    logic        mem_ce_n, mem_oe_n, mem_rd_n, mem_wr_n, mem_wdata_en;
    logic [3:0]  mem_be_n;
    logic [19:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #10 clk = ~clk;

    asmem_strobe_ctrl uut (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
        .rd_setup(rd_setup), .rd_strobe(rd_strobe), .rd_hold(rd_hold),
        .wr_setup(wr_setup), .wr_strobe(wr_strobe), .wr_hold(wr_hold),
        .mem_ce_n(mem_ce_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
        .mem_oe_n(mem_oe_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .mem_wdata(mem_wdata), .mem_wdata_en(mem_wdata_en),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    function automatic int eff(input logic [3:0] f);
        return (f == 4'd0) ? 1 : int'(f);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // drive a request at the current falling edge
    task automatic start(input vec_t v, input int mode);
        req       = 1'b1;
        req_we    = v.we;
        req_addr  = v.addr;
        req_be    = v.be;
        req_wdata = v.wd;
        mem_rdata = v.rd;
        if (v.we) begin
            wr_setup = v.s; wr_strobe = v.t; wr_hold = v.h;
            rd_setup = 4'd15; rd_strobe = 4'd15; rd_hold = 4'd15;
        end else begin
            rd_setup = v.s; rd_strobe = v.t; rd_hold = v.h;
            wr_setup = 4'd15; wr_strobe = 4'd15; wr_hold = 4'd15;
        end
        mem_ready = (mode == 0);
    endtask

    // walk one access cycle by cycle at falling edges
    task automatic collect(input vec_t v, input int mode, input int exp_gap,
                           input bit keep_req, input int exp_t);
        int gap = 0, sc = 0, tc = 0, hc = 0, iter = 0;
        bit started = 0, seen = 0, fin = 0;
        bit sel_ok = 1, strb_ok = 1, oe_ok = 1;
        bit sl, other;
        while (!fin && iter < 300) begin
            @(negedge clk);
            iter++;
            if (mem_ce_n) begin
                if (!started) gap++;
                else strb_ok = 0;
            end else begin
                started = 1;
                if (mem_addr !== v.addr || mem_be_n !== ~v.be || mem_wdata_en !== v.we ||
                    (v.we && mem_wdata !== v.wd))
                    sel_ok = 0;
                sl    = v.we ? !mem_wr_n : !mem_rd_n;
                other = v.we ? !mem_rd_n : !mem_wr_n;
                if (other) strb_ok = 0;
                if (mem_oe_n !== !(!v.we && sl)) oe_ok = 0;
                if (sl) begin
                    tc++;
                    seen = 1;
                    if (mode == 1 && tc == 1) mem_ready = 1'b1;
                    if (mode == 2 && tc == eff(v.t)) mem_ready = 1'b1;
                end else if (!seen) sc++;
                else hc++;
                if (ack) begin
                    fin = 1;
                    if (!keep_req) req = 1'b0;
                end
            end
        end
        check(fin, "R4", "access completed with ack", fin, 1);
        check(gap == exp_gap, "R11", "idle cycles before setup", gap, exp_gap);
        check(sc == eff(v.s), "R2", "setup cycles", sc, eff(v.s));
        check(tc == exp_t, "R3", "strobe cycles", tc, exp_t);
        check(hc == eff(v.h), "R4", "hold cycles (ack in last)", hc, eff(v.h));
        check(sel_ok, "R7", "selects and write data stable", sel_ok, 1);
        check(strb_ok, "R6", "other strobe idle, no early release", strb_ok, 1);
        check(oe_ok, "R6", "output enable tracks read strobe", oe_ok, 1);
        if (!v.we) check(rdata === v.rd, "R8", "read data at ack", rdata, v.rd);
    endtask

    task automatic post_idle(input vec_t v);
        @(negedge clk);
        check(ack === 1'b0 && mem_ce_n === 1'b1, "R4", "ack one cycle, ce released",
              {ack, mem_ce_n}, 2'b01);
        check(mem_wdata_en === 1'b0, "R7", "write bus released", mem_wdata_en, 0);
        if (!v.we) begin
            mem_rdata = ~v.rd;
            @(negedge clk);
            check(rdata === v.rd, "R8", "read data held", rdata, v.rd);
        end
    endtask

    initial begin
        vec_t d;
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_rd_n && mem_wr_n && mem_oe_n && !ack && !mem_wdata_en &&
              mem_be_n == 4'hF, "R1", "outputs in reset",
              {mem_ce_n, mem_rd_n, mem_wr_n, mem_oe_n, ack, mem_wdata_en}, 6'b111100);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(mem_ce_n && mem_rd_n && mem_wr_n && mem_oe_n && !ack && mem_be_n == 4'hF,
              "R1", "outputs idle after reset", {mem_ce_n, ack}, 2'b10);

        // table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            start(VEC[i], 0);
            collect(VEC[i], 0, 0, 1'b0, eff(VEC[i].t));
            post_idle(VEC[i]);
        end

        // R5: all-zero write fields give 1/1/1 even with read fields at 15
        d = '{1'b1, 20'h00777, 4'h5, 32'h11112222, 32'h0, 4'd0, 4'd0, 4'd0};
        start(d, 0);
        collect(d, 0, 0, 1'b0, 1);
        post_idle(d);

        // R9: ready low only early in the strobe is ignored
        d = '{1'b0, 20'h0AAAA, 4'hF, 32'h0, 32'h24681357, 4'd2, 4'd6, 4'd2};
        start(d, 1);
        collect(d, 1, 0, 1'b0, 6);
        post_idle(d);

        // R10: ready low until the last programmed strobe cycle -> C+3
        d = '{1'b0, 20'h0BBBB, 4'h3, 32'h0, 32'h99887766, 4'd1, 4'd3, 4'd1};
        start(d, 2);
        collect(d, 2, 0, 1'b0, 6);
        post_idle(d);

        // R10: one-cycle write strobe stretched to 4
        d = '{1'b1, 20'h0CCCC, 4'hC, 32'h55667788, 32'h0, 4'd1, 4'd1, 4'd2};
        start(d, 2);
        collect(d, 2, 0, 1'b0, 4);
        post_idle(d);

        // R11: back-to-back requests, one idle cycle between them
        start(VEC[1], 0);
        collect(VEC[1], 0, 0, 1'b1, eff(VEC[1].t));
        start(VEC[0], 0);
        collect(VEC[0], 0, 1, 1'b0, eff(VEC[0].t));
        post_idle(VEC[0]);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule